// File: doc/BRIEF.md
# Per-Channel Predicated Write Enable Unit

This block sits beside the result path of a pixel shader lane and decides, for each of the four colour channels of one pixel (red, green, blue, alpha), whether the current instruction's result is committed to the register file and whether it is pushed into the output FIFO. It also holds that pixel's four predicate bits. It updates them when an ALU instruction asks for it.

Each cycle carries one instruction. The colour channels share one predicate selector and one invert flag, and alpha has its own pair. A selector can turn predication off. It can give each channel its own predicate bit, or copy one chosen bit to every channel that selector governs. A flow-control instruction takes no per-channel enables. It gets a single go/no-go predicate from the colour selector. Write masks, output masks, the pixel-active flag and a write-inactive override complete the gating. The arithmetic, clamping and the sequencer that consumes the flow-control predicate sit outside this block.

Top module: `pwe_unit`

## Requirements
- R1: A selector code of 0 means no predication: the predicate term for the channels it governs is true, and its invert flag has no effect.
- R2: Selector code 1 on the colour selector makes red, green and blue use predicate bits 0, 1 and 2. Code 1 on the alpha selector makes alpha use predicate bit 3, the same as code 5.
- R3: Selector codes 2, 3, 4 and 5 copy predicate bit 0 (R), 1 (G), 2 (B) and 3 (A) to every channel that selector governs. Codes 6 and 7 are treated as no predication.
- R4: When the selector code is nonzero, the invert flag complements the selected predicate. The colour invert acts only on red, green and blue, and the alpha invert acts only on alpha.
- R5: Output bits are ordered as bit 0 R, bit 1 G, bit 2 B, bit 3 A. `rgb_wmask` bit 0/1/2 gates R/G/B and `a_wmask` gates A. For instruction kinds ALU (0), output (1) and texture (3), `rf_we[c]` is the AND of the channel's mask bit, its predicate term and the live term. It appears in the same cycle as the inputs.
- R6: The live term is `pix_active` OR `write_all`. An inactive pixel writes nothing unless `write_all` is set.
- R7: `fifo_we[c]` can be set only for an output instruction (kind 1). It is the AND of the output-mask bit (`rgb_omask` bits 0..2, `a_omask`), the predicate term and the live term.
- R8: For an ALU instruction, every channel whose output-mask bit, predicate term and live term are all true loads its predicate bit with `res_nz[c]` at the next rising clock edge. All other predicate bits, and every bit under other instruction kinds, keep their value.
- R9: For a flow-control instruction (kind 2), `rf_we` and `fifo_we` are zero. `flow_go` is the colour predicate term, where code 1 means all four predicate bits are set. The alpha selector and alpha invert are ignored. `flow_go` is 0 for other kinds.
- R10: An active-low reset clears all four predicate bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_kind | input | 2 | Instruction kind: 0 ALU, 1 output, 2 flow control, 3 texture |
| rgb_sel | input | 3 | Predicate selector for the colour channels (and for flow control) |
| rgb_inv | input | 1 | Invert flag for the colour predicate |
| a_sel | input | 3 | Predicate selector for alpha |
| a_inv | input | 1 | Invert flag for the alpha predicate |
| rgb_wmask | input | 3 | Register-file write mask, bit 0 R, bit 1 G, bit 2 B |
| a_wmask | input | 1 | Register-file write mask for alpha |
| rgb_omask | input | 3 | Output mask for R/G/B: FIFO gating or predicate-update choice |
| a_omask | input | 1 | Output mask for alpha |
| write_all | input | 1 | Write channels of inactive pixels too |
| pix_active | input | 1 | Pixel is active |
| res_nz | input | 4 | Per-channel ALU result is nonzero |
| rf_we | output | 4 | Register-file write enable per channel |
| fifo_we | output | 4 | Output-FIFO write enable per channel |
| flow_go | output | 1 | Predicate of the whole flow-control instruction |
| pred_q | output | 4 | Current predicate bits |

## Verification
The hardest situation to reach is an instruction whose outcome depends on a predicate state built by earlier ALU updates. This matters most when a channel's own predicate term decides whether that same bit gets updated, under an inverted replicate selector. The stimulus first writes known predicate patterns through unpredicated ALU instructions. Directed cases then use each selector code against those patterns. A long fixed-seed random run follows, in which ALU instructions keep changing the predicate while a bench model tracks it. The result is a mix of self-gated updates and mixed selectors that the bench predicts cycle by cycle.

// File: rtl/pwe_pkg.sv
package pwe_pkg;

   localparam int unsigned SEL_W = 3;

   typedef enum logic [1:0] {
      OP_ALU  = 2'd0,
      OP_OUT  = 2'd1,
      OP_FLOW = 2'd2,
      OP_TEX  = 2'd3
   } op_kind_e;

   localparam logic [SEL_W-1:0] SEL_OFF  = 3'd0;
   localparam logic [SEL_W-1:0] SEL_EACH = 3'd1;
   localparam int unsigned      SEL_REP_BASE = 2;

   // how independent mode resolves inside a selector instance
   typedef enum logic [0:0] {
      EACH_OWN_BIT = 1'b0,
      EACH_ALL_SET = 1'b1
   } each_mode_e;

endpackage

// File: rtl/pwe_pred_pick.sv
module pwe_pred_pick
   import pwe_pkg::*;
#(
   parameter int unsigned LANES         = 4,
   parameter int unsigned OWN_IDX       = 0,
   parameter each_mode_e  EACH_MODE     = EACH_OWN_BIT,
   parameter bit          RESERVED_PASS = 1'b1
) (
   input  logic [LANES-1:0] pred_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             inv_i,
   output logic             term_o
);

   localparam int unsigned LAST_CODE = SEL_REP_BASE + LANES - 1;

   if (OWN_IDX >= LANES) begin : g_bad_idx
      $error("pwe_pred_pick: OWN_IDX out of range");
   end
   if (LAST_CODE >= (1 << SEL_W)) begin : g_bad_codes
      $error("pwe_pred_pick: selector too narrow for LANES");
   end

   logic each_bit;
   logic rep_bit;
   logic rep_hit;
   logic reserved_term;

   // independent mode variant
   if (EACH_MODE == EACH_ALL_SET) begin : g_each_all
      assign each_bit = &pred_i;
   end else begin : g_each_own
      assign each_bit = pred_i[OWN_IDX];
   end

   // reserved selector code variant
   if (RESERVED_PASS) begin : g_res_pass
      assign reserved_term = 1'b1;
   end else begin : g_res_block
      assign reserved_term = 1'b0;
   end

   always_comb begin
      rep_bit = 1'b0;
      rep_hit = 1'b0;
      for (int k = 0; k < int'(LANES); k++) begin
         if (sel_i == SEL_W'(k + int'(SEL_REP_BASE))) begin
            rep_bit = pred_i[k];
            rep_hit = 1'b1;
         end
      end
   end

   always_comb begin
      if (sel_i == SEL_OFF) begin
         term_o = 1'b1;
      end else if (sel_i == SEL_EACH) begin
         term_o = each_bit ^ inv_i;
      end else if (rep_hit) begin
         term_o = rep_bit ^ inv_i;
      end else begin
         term_o = reserved_term;
      end
   end

endmodule

// File: rtl/pwe_lane_gate.sv
module pwe_lane_gate
   import pwe_pkg::*;
(
   input  op_kind_e op_i,
   input  logic     term_i,
   input  logic     live_i,
   input  logic     wmask_i,
   input  logic     omask_i,
   output logic     rf_we_o,
   output logic     fifo_we_o,
   output logic     pred_ld_o
);

   logic pass;

   assign pass = term_i & live_i;

   always_comb begin
      rf_we_o   = 1'b0;
      fifo_we_o = 1'b0;
      pred_ld_o = 1'b0;
      unique case (op_i)
         OP_ALU: begin
            rf_we_o   = wmask_i & pass;
            pred_ld_o = omask_i & pass;
         end
         OP_OUT: begin
            rf_we_o   = wmask_i & pass;
            fifo_we_o = omask_i & pass;
         end
         OP_TEX: begin
            rf_we_o   = wmask_i & pass;
         end
         OP_FLOW: begin
            rf_we_o   = 1'b0;
         end
         default: begin
            rf_we_o   = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/pwe_pred_reg.sv
module pwe_pred_reg #(
   parameter int unsigned LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] load_i,
   input  logic [LANES-1:0] val_i,
   output logic [LANES-1:0] q_o
);

   for (genvar c = 0; c < LANES; c++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_o[c] <= 1'b0;
         end else if (load_i[c]) begin
            q_o[c] <= val_i[c];
         end
      end

      // R8: a loaded bit takes the offered value on the next edge
      a_r8_load_value: assert property (@(posedge clk) disable iff (!rst_n)
         load_i[c] |=> (q_o[c] == $past(val_i[c])));

      // R8: an unloaded bit keeps its value
      a_r8_hold_value: assert property (@(posedge clk) disable iff (!rst_n)
         !load_i[c] |=> $stable(q_o[c]));
   end

endmodule

// File: rtl/pwe_unit.sv
module pwe_unit
   import pwe_pkg::*;
#(
   parameter int unsigned LANES         = 4,
   parameter int unsigned RGB_LANES     = 3,
   parameter bit          RESERVED_PASS = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           op_kind,
   input  logic [2:0]           rgb_sel,
   input  logic                 rgb_inv,
   input  logic [2:0]           a_sel,
   input  logic                 a_inv,
   input  logic [RGB_LANES-1:0] rgb_wmask,
   input  logic                 a_wmask,
   input  logic [RGB_LANES-1:0] rgb_omask,
   input  logic                 a_omask,
   input  logic                 write_all,
   input  logic                 pix_active,
   input  logic [LANES-1:0]     res_nz,
   output logic [LANES-1:0]     rf_we,
   output logic [LANES-1:0]     fifo_we,
   output logic                 flow_go,
   output logic [LANES-1:0]     pred_q
);

   localparam int unsigned ALPHA_IDX = LANES - 1;

   if (LANES != RGB_LANES + 1) begin : g_bad_split
      $error("pwe_unit: LANES must be RGB_LANES plus one alpha lane");
   end
   if (RGB_LANES != 3) begin : g_bad_rgb
      $error("pwe_unit: selector encoding assumes three colour lanes");
   end

   op_kind_e         op;
   logic             live;
   logic [LANES-1:0] wmask_all;
   logic [LANES-1:0] omask_all;
   logic [LANES-1:0] term;
   logic [LANES-1:0] pred_ld;
   logic             flow_term;

   assign op        = op_kind_e'(op_kind);
   assign live      = pix_active | write_all;
   assign wmask_all = {a_wmask, rgb_wmask};
   assign omask_all = {a_omask, rgb_omask};

   for (genvar c = 0; c < LANES; c++) begin : g_lane
      if (c < RGB_LANES) begin : g_colour
         pwe_pred_pick #(
            .LANES(LANES), .OWN_IDX(c),
            .EACH_MODE(EACH_OWN_BIT), .RESERVED_PASS(RESERVED_PASS)
         ) u_pick (
            .pred_i(pred_q), .sel_i(rgb_sel), .inv_i(rgb_inv), .term_o(term[c])
         );
      end else begin : g_alpha
         pwe_pred_pick #(
            .LANES(LANES), .OWN_IDX(ALPHA_IDX),
            .EACH_MODE(EACH_OWN_BIT), .RESERVED_PASS(RESERVED_PASS)
         ) u_pick (
            .pred_i(pred_q), .sel_i(a_sel), .inv_i(a_inv), .term_o(term[c])
         );
      end

      pwe_lane_gate u_gate (
         .op_i      (op),
         .term_i    (term[c]),
         .live_i    (live),
         .wmask_i   (wmask_all[c]),
         .omask_i   (omask_all[c]),
         .rf_we_o   (rf_we[c]),
         .fifo_we_o (fifo_we[c]),
         .pred_ld_o (pred_ld[c])
      );
   end

   pwe_pred_pick #(
      .LANES(LANES), .OWN_IDX(0),
      .EACH_MODE(EACH_ALL_SET), .RESERVED_PASS(RESERVED_PASS)
   ) u_flow_pick (
      .pred_i(pred_q), .sel_i(rgb_sel), .inv_i(rgb_inv), .term_o(flow_term)
   );

   assign flow_go = (op == OP_FLOW) & flow_term;

   pwe_pred_reg #(.LANES(LANES)) u_pred (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (pred_ld),
      .val_i  (res_nz),
      .q_o    (pred_q)
   );

   // R6: a dead pixel without the override writes nothing anywhere
   a_r6_dead_pixel: assert property (@(posedge clk) disable iff (!rst_n)
      (!pix_active && !write_all) |-> (rf_we == '0 && fifo_we == '0));

   // R7: FIFO enables appear only for output instructions
   a_r7_fifo_only_out: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_we != '0) |-> (op_kind == 2'd1));

   // R9: flow control commits no channel
   a_r9_flow_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (op_kind == 2'd2) |-> (rf_we == '0 && fifo_we == '0));

   // R8: predicate bits move only under ALU instructions
   a_r8_non_alu_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (op_kind != 2'd0) |=> $stable(pred_q));

   // R1: unpredicated red lane with mask and live term always writes
   a_r1_off_writes: assert property (@(posedge clk) disable iff (!rst_n)
      (rgb_sel == 3'd0 && rgb_wmask[0] && (pix_active || write_all)
       && op_kind != 2'd2) |-> rf_we[0]);

   // R9: flow_go never asserted outside flow control
   a_r9_go_only_flow: assert property (@(posedge clk) disable iff (!rst_n)
      flow_go |-> (op_kind == 2'd2));

endmodule

// File: tb/pwe_unit_test.sv
`timescale 1ns/100ps
module pwe_unit_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] op_kind = '0;
   logic [2:0] rgb_sel = '0;
   logic       rgb_inv = 1'b0;
   logic [2:0] a_sel = '0;
   logic       a_inv = 1'b0;
   logic [2:0] rgb_wmask = '0;
   logic       a_wmask = 1'b0;
   logic [2:0] rgb_omask = '0;
   logic       a_omask = 1'b0;
   logic       write_all = 1'b0;
   logic       pix_active = 1'b0;
   logic [3:0] res_nz = '0;
   logic [3:0] rf_we, fifo_we, pred_q;
   logic       flow_go;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [3:0] mp = '0;   // bench copy of predicate state

   always #2.5 clk = ~clk;

   pwe_unit uut (
      .clk(clk), .rst_n(rst_n), .op_kind(op_kind),
      .rgb_sel(rgb_sel), .rgb_inv(rgb_inv), .a_sel(a_sel), .a_inv(a_inv),
      .rgb_wmask(rgb_wmask), .a_wmask(a_wmask),
      .rgb_omask(rgb_omask), .a_omask(a_omask),
      .write_all(write_all), .pix_active(pix_active), .res_nz(res_nz),
      .rf_we(rf_we), .fifo_we(fifo_we), .flow_go(flow_go), .pred_q(pred_q)
   );

   function automatic bit term_of(input logic [3:0] p, input logic [2:0] s,
                                  input logic inv, input int lane, input bit flow);
      bit b;
      if (s == 3'd0) return 1'b1;          // R1
      if (s > 3'd5) return 1'b1;           // R3 reserved codes
      if (s == 3'd1) b = flow ? (&p) : p[lane];   // R2 / R9
      else b = p[s - 3'd2];                // R3
      return b ^ inv;                      // R4
   endfunction

   function automatic logic [3:0] lane_terms(input logic [3:0] p);
      logic [3:0] t;
      for (int c = 0; c < 3; c++) t[c] = term_of(p, rgb_sel, rgb_inv, c, 1'b0);
      t[3] = term_of(p, a_sel, a_inv, 3, 1'b0);
      return t;
   endfunction

   task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   // Apply current inputs for one cycle: check combinational outputs, then the
   // predicate after the edge.
   task automatic step(input string tag);
      logic [3:0] t, wm, om, erf, efifo, ld;
      bit live, eflow;
      #1;
      t     = lane_terms(mp);
      wm    = {a_wmask, rgb_wmask};
      om    = {a_omask, rgb_omask};
      live  = pix_active | write_all;
      erf   = (op_kind != 2'd2 && live) ? (wm & t) : 4'b0;
      efifo = (op_kind == 2'd1 && live) ? (om & t) : 4'b0;
      eflow = (op_kind == 2'd2) && term_of(mp, rgb_sel, rgb_inv, 0, 1'b1);
      ld    = (op_kind == 2'd0 && live) ? (om & t) : 4'b0;
      chk({tag, " rf_we"}, rf_we, erf);
      chk({tag, " fifo_we"}, fifo_we, efifo);
      chk({tag, " flow_go"}, {3'b0, flow_go}, {3'b0, eflow});
      @(posedge clk);
      mp = (mp & ~ld) | (res_nz & ld);
      #1;
      chk({tag, " pred_q"}, pred_q, mp);
      @(negedge clk);
   endtask

   task automatic set_instr(input logic [1:0] k, input logic [2:0] rs, input logic ri,
                            input logic [2:0] as, input logic ai,
                            input logic [3:0] wm, input logic [3:0] om,
                            input logic act, input logic wall, input logic [3:0] nz);
      op_kind = k; rgb_sel = rs; rgb_inv = ri; a_sel = as; a_inv = ai;
      rgb_wmask = wm[2:0]; a_wmask = wm[3]; rgb_omask = om[2:0]; a_omask = om[3];
      pix_active = act; write_all = wall; res_nz = nz;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'h5eed_0042);
      repeat (3) @(negedge clk);
      chk("R10 reset clears predicate", pred_q, 4'b0000);
      rst_n = 1'b1;
      @(negedge clk);

      // R8: unpredicated ALU loads 0101 into all bits
      set_instr(2'd0, 3'd0, 1'b1, 3'd0, 1'b1, 4'b0000, 4'b1111, 1'b1, 1'b0, 4'b0101);
      step("R8 full load");
      chk("R8 value 0101", pred_q, 4'b0101);
      // R8: only G selected by the output mask
      set_instr(2'd0, 3'd0, 1'b0, 3'd0, 1'b0, 4'b0000, 4'b0010, 1'b1, 1'b0, 4'b1111);
      step("R8 partial load");
      chk("R8 value 0111", pred_q, 4'b0111);
      // R1: sel 0 with invert set still writes every masked lane
      set_instr(2'd3, 3'd0, 1'b1, 3'd0, 1'b1, 4'b1111, 4'b0000, 1'b1, 1'b0, 4'b0000);
      step("R1 no predication");
      // R2: independent mode, alpha uses bit 3 (clear) -> rf_we 0111
      set_instr(2'd3, 3'd1, 1'b0, 3'd1, 1'b0, 4'b1111, 4'b0000, 1'b1, 1'b0, 4'b0000);
      #1; chk("R2 independent", rf_we, 4'b0111); @(negedge clk);
      step("R2 independent");
      // R3: replicate A (clear) to RGB, replicate R (set) to alpha -> 1000
      set_instr(2'd3, 3'd5, 1'b0, 3'd2, 1'b0, 4'b1111, 4'b0000, 1'b1, 1'b0, 4'b0000);
      #1; chk("R3 replicate", rf_we, 4'b1000); @(negedge clk);
      step("R3 replicate");
      // R3: reserved code 6 behaves as unpredicated
      set_instr(2'd3, 3'd6, 1'b1, 3'd7, 1'b1, 4'b1111, 4'b0000, 1'b1, 1'b0, 4'b0000);
      #1; chk("R3 reserved codes", rf_we, 4'b1111); @(negedge clk);
      // R4: invert on colour only -> RGB get ~A=1, alpha gets A=0
      set_instr(2'd1, 3'd5, 1'b1, 3'd5, 1'b0, 4'b1111, 4'b1111, 1'b1, 1'b0, 4'b0000);
      #1; chk("R4 colour invert", fifo_we, 4'b0111); @(negedge clk);
      step("R4 invert");
      // R5: write mask bit positions, value 5 means R and B
      set_instr(2'd0, 3'd0, 1'b0, 3'd0, 1'b0, 4'b0101, 4'b0000, 1'b1, 1'b0, 4'b0000);
      #1; chk("R5 mask positions", rf_we, 4'b0101); @(negedge clk);
      // R6: inactive pixel, then override
      set_instr(2'd1, 3'd0, 1'b0, 3'd0, 1'b0, 4'b1111, 4'b1111, 1'b0, 1'b0, 4'b1111);
      step("R6 inactive blocked");
      set_instr(2'd1, 3'd0, 1'b0, 3'd0, 1'b0, 4'b1111, 4'b1111, 1'b0, 1'b1, 4'b1111);
      #1; chk("R6 write_all override", rf_we, 4'b1111); @(negedge clk);
      // R7: texture with omask set leaves FIFO idle
      set_instr(2'd3, 3'd0, 1'b0, 3'd0, 1'b0, 4'b1111, 4'b1111, 1'b1, 1'b0, 4'b1111);
      step("R7 no fifo outside output");
      // R9: flow control, independent -> AND of 0111 = 0; alpha fields ignored
      set_instr(2'd2, 3'd1, 1'b0, 3'd0, 1'b1, 4'b1111, 4'b1111, 1'b1, 1'b0, 4'b1111);
      #1; chk("R9 flow independent", {3'b0, flow_go}, 4'b0000); @(negedge clk);
      set_instr(2'd2, 3'd1, 1'b1, 3'd5, 1'b0, 4'b1111, 4'b1111, 1'b1, 1'b0, 4'b1111);
      #1; chk("R9 flow inverted, alpha ignored", {3'b0, flow_go}, 4'b0001); @(negedge clk);
      step("R9 flow");

      // constrained random mix
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = $urandom_range(0, 9);
         set_instr(r < 4 ? 2'd0 : 2'($urandom_range(0, 3)),
                   3'($urandom_range(0, 7)), 1'($urandom),
                   3'($urandom_range(0, 7)), 1'($urandom),
                   4'($urandom), 4'($urandom),
                   ($urandom_range(0, 3) != 0), ($urandom_range(0, 4) == 0),
                   4'($urandom));
         step("R5/R7/R8/R9 random");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule